// File: doc/BRIEF.md
# Quadrature Down-Converter with Leaky-Integrator Smoothing

This block turns a stream of real-valued FM samples riding on an intermediate carrier into a complex baseband pair. A local oscillator is built from a phase accumulator and a 16-entry sinusoid table. Each accepted sample is multiplied by the oscillator cosine and, separately, by the oscillator sine. Each product feeds its own single-pole recursive low-pass filter. The sine branch is sign-inverted at the output, so the pair leaves the block as the conjugate baseband signal that a phase-difference demodulator expects.

The oscillator moves forward only on accepted samples. At the default settings it steps one sixteenth of a cycle per sample, which places a carrier at one sixteenth of the sample rate at DC. Results appear as a one-cycle valid pulse two clock cycles after the input strobe. Between pulses the outputs hold their last values.

Top module: `fm_quad_downconv`

## Requirements
- R1: A synchronous active-low reset clears the oscillator phase and both filter states. While reset is held and on the cycle after it, out_valid is 0 and out_i and out_q are 0.
- R2: The oscillator phase advances by exactly one table step (one sixteenth of a cycle) for each cycle in which in_valid is 1, and it does not move on cycles with in_valid at 0. The first sample after reset uses table index 0.
- R3: The sine table at index k (0..15) holds 0, 49, 90, 117, 127, 117, 90, 49, 0, -49, -90, -117, -127, -117, -90, -49. The cosine is read at index (k+4) mod 16. Each sample x is multiplied as x*cos and x*sin, both signed.
- R4: Each branch updates as y_new = p + y_old - (y_old >>> 4), where p is that branch's product and >>> is an arithmetic (floor) shift. out_i is the cosine-branch state.
- R5: out_q is the two's-complement negation of the sine-branch state.
- R6: out_valid is 1 exactly two clock cycles after a cycle with in_valid at 1, and 0 otherwise. There is one pulse per accepted sample, and samples may arrive back to back.
- R7: When out_valid is 0, out_i and out_q keep their previous values.
- R8: With any 8-bit input sequence, both filter states stay within ±(16*16256+15) and never wrap.
- R9: For an input made of a DC offset plus a tone at the carrier, after settling the mean of out_i over one carrier period is a positive constant, and the mean of out_q is below one eighth of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 8 | Signed input sample |
| out_valid | output | 1 | Output pair strobe |
| out_i | output | 21 | Signed in-phase result |
| out_q | output | 21 | Signed quadrature result (negated sine branch) |

## Verification
The assertions assume that in_valid is a plain per-cycle strobe with no handshake. They also assume that in_sample is any two's-complement 8-bit value, so the filter bound has to hold even for the extreme value -128 against the table peak. The random phase of the stimulus draws samples over the full 8-bit range, biased toward -128 and 127. It drops the strobe on random cycles so that both back-to-back and gapped arrivals occur. Directed phases add single isolated samples after reset and a DC-offset carrier tone, and all of these stay within the input assumptions.

// File: rtl/qmix_pkg.sv
package qmix_pkg;
    // Table geometry: 16 entries per carrier cycle, quarter-wave symmetric
    localparam int TBL_ADDR_W = 4;
    localparam int TBL_DEPTH  = 1 << TBL_ADDR_W;
    localparam int COS_OFFSET = TBL_DEPTH / 4;
    // Filter pole 1 - 2^-SHIFT = 15/16
    localparam int POLE_SHIFT = 4;

    // Quarter-wave amplitude for index 0..4 of a 16-entry table at peak 127
    function automatic int quarter_amp(input int k);
        case (k)
            0:       quarter_amp = 0;
            1:       quarter_amp = 49;
            2:       quarter_amp = 90;
            3:       quarter_amp = 117;
            default: quarter_amp = 127;
        endcase
    endfunction

    // Full-cycle sine value for a 4-bit table index
    function automatic int sine_entry(input int idx);
        int q;
        int r;
        q = (idx >> 2) & 3;
        r = idx & 3;
        case (q)
            0:       sine_entry = quarter_amp(r);
            1:       sine_entry = quarter_amp(4 - r);
            2:       sine_entry = -quarter_amp(r);
            default: sine_entry = -quarter_amp(4 - r);
        endcase
    endfunction
endpackage

// File: rtl/qmix_dds.sv
// Local oscillator: registered phase accumulator plus sinusoid table.
// Assumes PHASE_W >= TBL_ADDR_W; the table index is the top TBL_ADDR_W
// phase bits. Phase moves only when adv is high.
module qmix_dds
    import qmix_pkg::*;
#(
    parameter int PHASE_W   = 8,
    parameter int PHASE_INC = 16,
    parameter int LUT_W     = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    adv,
    output logic signed [LUT_W-1:0] sin_o,
    output logic signed [LUT_W-1:0] cos_o
);
    localparam logic [PHASE_W-1:0] INC = PHASE_W'(PHASE_INC);

    logic [PHASE_W-1:0]    phase;
    logic [TBL_ADDR_W-1:0] idx_s;
    logic [TBL_ADDR_W-1:0] idx_c;
    logic signed [LUT_W-1:0] table_w [TBL_DEPTH];

    // Table contents computed from the quarter-wave function
    for (genvar k = 0; k < TBL_DEPTH; k++) begin : g_tbl
        assign table_w[k] = LUT_W'(sine_entry(k));
    end

    // Phase accumulator, stepped once per accepted sample
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else if (adv)
            phase <= phase + INC;
    end

    assign idx_s = phase[PHASE_W-1 -: TBL_ADDR_W];
    assign idx_c = idx_s + TBL_ADDR_W'(COS_OFFSET);
    assign sin_o = table_w[idx_s];
    assign cos_o = table_w[idx_c];

    // R2
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> phase == $past(phase) + INC);
    // R2
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(phase));
endmodule

// File: rtl/qmix_mult_stage.sv
// Mixer stage: registers the products of the input sample with the
// oscillator cosine and sine, plus a valid bit. Products hold when idle.
module qmix_mult_stage #(
    parameter int IN_W  = 8,
    parameter int LUT_W = 8,
    localparam int PROD_W = IN_W + LUT_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     vld_i,
    input  logic signed [IN_W-1:0]   x_i,
    input  logic signed [LUT_W-1:0]  cos_i,
    input  logic signed [LUT_W-1:0]  sin_i,
    output logic                     vld_o,
    output logic signed [PROD_W-1:0] pc_o,
    output logic signed [PROD_W-1:0] ps_o
);
    // Capture both products on an accepted sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o <= 1'b0;
            pc_o  <= '0;
            ps_o  <= '0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                pc_o <= x_i * cos_i;
                ps_o <= x_i * sin_i;
            end
        end
    end

    // R6
    stage_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |=> vld_o);
endmodule

// File: rtl/qmix_leaky_int.sv
// Single-pole recursive low-pass: y = x + y - (y >>> SHIFT).
// Assumes |x| <= X_MAX; ACC_W must hold 2^SHIFT * X_MAX + 2^SHIFT.
module qmix_leaky_int #(
    parameter int X_W   = 16,
    parameter int SHIFT = 4,
    parameter int X_MAX = 16256,
    localparam int ACC_W = X_W + SHIFT + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic signed [X_W-1:0]   x_i,
    output logic signed [ACC_W-1:0] y_o
);
    localparam logic signed [ACC_W-1:0] Y_LIM =
        ACC_W'((X_MAX << SHIFT) + (1 << SHIFT) - 1);

    logic signed [ACC_W-1:0] x_ext;
    logic signed [ACC_W-1:0] leak;

    assign x_ext = {{(ACC_W-X_W){x_i[X_W-1]}}, x_i};
    assign leak  = y_o >>> SHIFT;

    // State update on each product
    always_ff @(posedge clk) begin
        if (!rst_n)
            y_o <= '0;
        else if (en)
            y_o <= x_ext + y_o - leak;
    end

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (y_o <= Y_LIM) && (y_o >= -Y_LIM));
    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(y_o));
endmodule

// File: rtl/fm_quad_downconv.sv
// Quadrature down-converter: DDS mixing, per-branch leaky integrator,
// negated quadrature branch. Latency two cycles from in_valid to out_valid.
// Assumes in_valid is a per-cycle strobe with no back-pressure.
module fm_quad_downconv
    import qmix_pkg::*;
#(
    parameter int IN_W      = 8,
    parameter int LUT_W     = 8,
    parameter int PHASE_W   = 8,
    parameter int PHASE_INC = 16,
    localparam int PROD_W   = IN_W + LUT_W,
    localparam int ACC_W    = PROD_W + POLE_SHIFT + 1,
    localparam int PROD_MAX = (1 << (IN_W-1)) * ((1 << (LUT_W-1)) - 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [IN_W-1:0]         in_sample,
    output logic                    out_valid,
    output logic [ACC_W-1:0]        out_i,
    output logic [ACC_W-1:0]        out_q
);
    logic signed [LUT_W-1:0]  lo_sin;
    logic signed [LUT_W-1:0]  lo_cos;
    logic                     mix_vld;
    logic signed [PROD_W-1:0] mix_c;
    logic signed [PROD_W-1:0] mix_s;
    logic signed [ACC_W-1:0]  acc_i;
    logic signed [ACC_W-1:0]  acc_s;

    qmix_dds #(.PHASE_W(PHASE_W), .PHASE_INC(PHASE_INC), .LUT_W(LUT_W)) u_dds (
        .clk(clk), .rst_n(rst_n), .adv(in_valid), .sin_o(lo_sin), .cos_o(lo_cos)
    );

    qmix_mult_stage #(.IN_W(IN_W), .LUT_W(LUT_W)) u_mix (
        .clk(clk), .rst_n(rst_n), .vld_i(in_valid), .x_i($signed(in_sample)),
        .cos_i(lo_cos), .sin_i(lo_sin), .vld_o(mix_vld), .pc_o(mix_c), .ps_o(mix_s)
    );

    qmix_leaky_int #(.X_W(PROD_W), .SHIFT(POLE_SHIFT), .X_MAX(PROD_MAX)) u_lpf_i (
        .clk(clk), .rst_n(rst_n), .en(mix_vld), .x_i(mix_c), .y_o(acc_i)
    );

    qmix_leaky_int #(.X_W(PROD_W), .SHIFT(POLE_SHIFT), .X_MAX(PROD_MAX)) u_lpf_q (
        .clk(clk), .rst_n(rst_n), .en(mix_vld), .x_i(mix_s), .y_o(acc_s)
    );

    // Output valid follows the mixer stage by one cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else
            out_valid <= mix_vld;
    end

    assign out_i = acc_i;
    assign out_q = -acc_s;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_i == '0 && out_q == '0));
    // R6
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mix_vld |=> out_valid);
    // R6
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mix_vld |=> !out_valid);
    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mix_vld |=> ($stable(out_i) && $stable(out_q)));
endmodule

// File: tb/tb_fm_quad_downconv.sv
module tb_fm_quad_downconv;
    localparam int W = 21;
    localparam int LIM = 16 * 16256 + 15;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [7:0]   in_sample = '0;
    logic         out_valid;
    logic [W-1:0] out_i;
    logic [W-1:0] out_q;

    fm_quad_downconv dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int m_ph = 0;
    int m_yi = 0;
    int m_ys = 0;
    int exp_i[$];
    int exp_q[$];
    logic [1:0] vhist = '0;
    int last_i = 0;
    int last_q = 0;
    int ring_i[16];
    int ring_q[16];
    int ring_n = 0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic int tsin(input int k);
        int t[16] = '{0, 49, 90, 117, 127, 117, 90, 49, 0, -49, -90, -117, -127, -117, -90, -49};
        return t[k & 15];
    endfunction

    function automatic int sx(input logic [W-1:0] v);
        return int'($signed(v));
    endfunction

    // Reference model step for one accepted sample (R2, R3, R4, R5)
    task automatic model_push(input int x);
        int pc;
        int ps;
        pc = x * tsin(m_ph + 4);
        ps = x * tsin(m_ph);
        m_yi = pc + m_yi - (m_yi >>> 4);
        m_ys = ps + m_ys - (m_ys >>> 4);
        m_ph = (m_ph + 1) & 15;
        exp_i.push_back(m_yi);
        exp_q.push_back(-m_ys);
    endtask

    task automatic send(input int x);
        in_valid  = 1'b1;
        in_sample = 8'(x);
        model_push(x);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        m_ph = 0; m_yi = 0; m_ys = 0;
        exp_i.delete(); exp_q.delete();
        rst_n = 1'b1;
    endtask

    // Valid history sampled at the same edge as the design
    always @(posedge clk) begin
        if (!rst_n) vhist <= '0;
        else        vhist <= {vhist[0], in_valid};
    end

    // Output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            last_i <= 0;
            last_q <= 0;
        end else begin
            chk(out_valid == vhist[1], "R6 valid timing", int'(out_valid), int'(vhist[1]));
            if (out_valid) begin
                if (exp_i.size() == 0) begin
                    chk(1'b0, "R6 unexpected output", 1, 0);
                end else begin
                    int ei;
                    int eq;
                    ei = exp_i.pop_front();
                    eq = exp_q.pop_front();
                    chk(sx(out_i) == ei, "R4 out_i", sx(out_i), ei);
                    chk(sx(out_q) == eq, "R5 out_q", sx(out_q), eq);
                    chk(sx(out_i) <= LIM && sx(out_i) >= -LIM, "R8 bound", sx(out_i), LIM);
                end
                ring_i[ring_n & 15] = sx(out_i);
                ring_q[ring_n & 15] = sx(out_q);
                ring_n++;
            end else begin
                chk(sx(out_i) == last_i && sx(out_q) == last_q, "R7 hold", sx(out_i), last_i);
            end
            last_i <= sx(out_i);
            last_q <= sx(out_q);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20151124));
        @(negedge clk);
        do_reset();
        // R1: reset state
        chk(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
        chk(sx(out_i) == 0 && sx(out_q) == 0, "R1 outputs after reset", sx(out_i), 0);

        // R3: first sample at index 0 gives x*127 on I, zero on Q
        send(100);
        @(negedge clk);
        chk(sx(out_i) == 12700, "R3 first I", sx(out_i), 12700);
        chk(sx(out_q) == 0, "R3 first Q", sx(out_q), 0);
        idle(3);
        // R2/R5: gap did not advance phase; index 1 gives cos 117, sin 49
        send(100);
        @(negedge clk);
        chk(sx(out_i) == 23607, "R2 second I", sx(out_i), 23607);
        chk(sx(out_q) == -4900, "R5 second Q", sx(out_q), -4900);
        idle(4);

        // R8: full-scale extremes back to back
        for (int k = 0; k < 64; k++) send((k % 2) ? -128 : 127);
        for (int k = 0; k < 64; k++) send(-128);
        idle(4);

        // Random stream with random gaps (R2, R4, R6, R7)
        for (int k = 0; k < 3000; k++) begin
            int r;
            r = int'($urandom_range(0, 9));
            if (r < 3) begin
                idle(1);
            end else begin
                int x;
                x = (r == 9) ? -128 : (r == 8) ? 127 : int'($urandom_range(0, 255)) - 128;
                send(x);
            end
        end
        idle(4);

        // Mid-run reset then DC offset plus carrier tone (R1, R9)
        do_reset();
        chk(sx(out_i) == 0 && sx(out_q) == 0, "R1 mid-run reset", sx(out_i), 0);
        for (int n = 0; n < 320; n++) send(20 + tsin(n + 4) / 2);
        idle(4);
        begin
            int si;
            int sq;
            si = 0; sq = 0;
            for (int k = 0; k < 16; k++) begin
                si += ring_i[k];
                sq += ring_q[k];
            end
            si /= 16; sq /= 16;
            chk(si > 0, "R9 mean I positive", si, 1);
            chk((sq < 0 ? -sq : sq) * 8 < si, "R9 mean Q near zero", sq, 0);
        end
        chk(exp_i.size() == 0, "R6 all outputs seen", exp_i.size(), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule